// File: doc/BRIEF.md
# Floating-point control, status and exception register

This block holds the 32-bit control and status word of a floating-point unit. Software reads the whole word through a read port and replaces it through a control-move write port. Each completing floating-point instruction reports its class, six raw exception indications, a denormal-result flag and, for compares, a result and a condition-bit index. The block updates the cause, sticky-flag and condition fields from this report.

The block raises an exception request whenever a cause bit meets its enable. The unimplemented-operation cause has no enable bit and always raises the request. The block also drives the rounding mode and the flush-to-zero control to the arithmetic units. It models no datapath, rounding or stall logic.

Top module: `fp_csr`

## Requirements
- R1: While rst_ni is low, and in the cycle after it rises, rd_data_o is 0, exc_req_o is 0, rmode_o is 0 and flush_o is 0.
- R2: Bits 22:18 of rd_data_o always read as 0. A control write leaves them at 0 whatever value it carries.
- R3: A control write (wr_en_i=1) loads every other bit from wr_data_i on the next clock edge. When a control write and a completion arrive in the same cycle, the write wins.
- R4: Classes on done_class_i are 0 other, 1 arithmetic, 2 divide and 3 compare. A completion of class 1 or 2 overwrites the whole cause field with the new indications, clearing bits that instruction did not raise. The cause field is bit 17 E, 16 V, 15 Z, 14 O, 13 U and 12 I. Classes 0 and 3 leave the cause field unchanged.
- R5: The flag bits are 6 V, 5 Z, 4 O, 3 U and 2 I. An arithmetic or divide completion ORs its new V..I causes into the flags. Flags never clear except through a control write.
- R6: The raw indications on done_exc_i are bit 5 unimplemented, 4 invalid, 3 divide-by-zero, 2 overflow, 1 underflow and 0 inexact. Raw bit 3 sets the Z cause only for class 2. Under class 1 the Z cause is cleared.
- R7: When FS (bit 24) is 0, done_denorm_i sets the E cause. When FS is 1, a denormal result sets no E cause.
- R8: A class 3 completion writes done_cmp_i into condition bit done_cidx_i. Index 0 is stored in bit 23 and index k (1..7) in bit 24+k. No other bit changes.
- R9: exc_req_o is high exactly when E is set, or when any of the V..I causes is set together with its enable. The enables are bit 11 V, 10 Z, 9 O, 8 U and 7 I. The request follows both cause updates and enable changes made by control writes.
- R10: rmode_o always equals bits 1:0 and flush_o always equals bit 24. The rounding-mode codes are 0 nearest-even, 1 toward zero, 2 toward plus infinity and 3 toward minus infinity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Control-move write strobe |
| wr_data_i | input | 32 | Control-move write data |
| rd_data_o | output | 32 | Current register value |
| done_valid_i | input | 1 | Instruction completion strobe |
| done_class_i | input | 2 | Completion class (other, arithmetic, divide, compare) |
| done_exc_i | input | 6 | Raw exception indications |
| done_denorm_i | input | 1 | Result was denormalized |
| done_cmp_i | input | 1 | Compare result |
| done_cidx_i | input | 3 | Condition bit index for compares |
| rmode_o | output | 2 | Rounding mode to the arithmetic units |
| flush_o | output | 1 | Flush-to-zero control |
| exc_req_o | output | 1 | Exception request |

## Verification
The assertions take it that every input is driven to a known value from reset onward. They also take it that done_class_i always carries one of the four codes, which holds because the field is fully decoded. The sticky-flag and cause-hold properties hold only in cycles with no control write, so they are gated on wr_en_i low. The stimulus drives every input from time zero. It issues control writes only in a minority of cycles, so flags accumulate over long stretches between writes, and it mixes in cycles where a write and a completion collide.

// File: rtl/fp_csr_pkg.sv
package fp_csr_pkg;
  localparam int unsigned XLEN      = 32;
  localparam int unsigned NCOND     = 8;
  localparam int unsigned CIDX_W    = $clog2(NCOND);
  localparam int unsigned NIEEE     = 5;
  localparam int unsigned NCAUSE    = NIEEE + 1;
  localparam int unsigned RM_W      = 2;
  localparam int unsigned FLAG_LSB  = 2;
  localparam int unsigned EN_LSB    = FLAG_LSB + NIEEE;
  localparam int unsigned CAUSE_LSB = EN_LSB + NIEEE;
  localparam int unsigned RSV_LSB   = CAUSE_LSB + NCAUSE;
  localparam int unsigned RSV_W     = 5;
  localparam int unsigned C0_BIT    = RSV_LSB + RSV_W;
  localparam int unsigned FS_BIT    = C0_BIT + 1;
  localparam int unsigned CHI_LSB   = FS_BIT + 1;
  localparam logic [XLEN-1:0] RSV_MASK =
    {{(XLEN-RSV_W){1'b0}}, {RSV_W{1'b1}}} << RSV_LSB;

  typedef enum logic [1:0] {
    CLS_OTHER = 2'd0,
    CLS_ARITH = 2'd1,
    CLS_DIV   = 2'd2,
    CLS_CMP   = 2'd3
  } op_class_e;

  // cause bit order, MSB first: E V Z O U I
  localparam int unsigned CB_E = 5;
  localparam int unsigned CB_Z = 3;

  function automatic int unsigned cond_pos(int unsigned idx);
    return (idx == 0) ? C0_BIT : CHI_LSB + idx - 1;
  endfunction
endpackage

// File: rtl/fp_csr_cause.sv
module fp_csr_cause
  import fp_csr_pkg::*;
(
  input  logic              valid_i,
  input  op_class_e         class_i,
  input  logic [NCAUSE-1:0] raw_i,
  input  logic              denorm_i,
  input  logic              fs_i,
  output logic              upd_o,
  output logic [NCAUSE-1:0] cause_o
);
  logic is_div;
  assign is_div = (class_i == CLS_DIV);
  assign upd_o  = valid_i & ((class_i == CLS_ARITH) | is_div);

  always_comb begin
    cause_o       = raw_i;
    cause_o[CB_E] = raw_i[CB_E] | (denorm_i & ~fs_i);
    cause_o[CB_Z] = raw_i[CB_Z] & is_div;
  end
endmodule

// File: rtl/fp_csr_cond.sv
module fp_csr_cond
  import fp_csr_pkg::*;
(
  input  logic [NCOND-1:0]  cond_q_i,
  input  logic              set_i,
  input  logic [CIDX_W-1:0] idx_i,
  input  logic              res_i,
  output logic [NCOND-1:0]  cond_d_o
);
  for (genvar i = 0; i < NCOND; i++) begin : g_cond
    assign cond_d_o[i] = (set_i && idx_i == CIDX_W'(i)) ? res_i : cond_q_i[i];
  end
endmodule

// File: rtl/fp_csr_trap.sv
module fp_csr_trap
  import fp_csr_pkg::*;
(
  input  logic [NCAUSE-1:0] cause_i,
  input  logic [NIEEE-1:0]  en_i,
  output logic              req_o
);
  assign req_o = cause_i[CB_E] | (|(cause_i[NIEEE-1:0] & en_i));
endmodule

// File: rtl/fp_csr.sv
module fp_csr
  import fp_csr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [XLEN-1:0]   wr_data_i,
  output logic [XLEN-1:0]   rd_data_o,
  input  logic              done_valid_i,
  input  logic [1:0]        done_class_i,
  input  logic [NCAUSE-1:0] done_exc_i,
  input  logic              done_denorm_i,
  input  logic              done_cmp_i,
  input  logic [CIDX_W-1:0] done_cidx_i,
  output logic [RM_W-1:0]   rmode_o,
  output logic              flush_o,
  output logic              exc_req_o
);
  logic [XLEN-1:0]   csr_q, csr_d;
  logic [NCAUSE-1:0] new_cause;
  logic              cause_upd;
  logic [NCOND-1:0]  cond_q, cond_d;
  logic              cmp_set;
  op_class_e         cls;

  assign cls     = op_class_e'(done_class_i);
  assign cmp_set = done_valid_i & (cls == CLS_CMP);

  for (genvar i = 0; i < NCOND; i++) begin : g_cond_map
    assign cond_q[i] = csr_q[cond_pos(i)];
  end

  fp_csr_cause u_cause (
    .valid_i  (done_valid_i),
    .class_i  (cls),
    .raw_i    (done_exc_i),
    .denorm_i (done_denorm_i),
    .fs_i     (csr_q[FS_BIT]),
    .upd_o    (cause_upd),
    .cause_o  (new_cause)
  );

  fp_csr_cond u_cond (
    .cond_q_i (cond_q),
    .set_i    (cmp_set),
    .idx_i    (done_cidx_i),
    .res_i    (done_cmp_i),
    .cond_d_o (cond_d)
  );

  always_comb begin
    csr_d = csr_q;
    if (wr_en_i) begin
      csr_d = wr_data_i & ~RSV_MASK;
    end else begin
      if (cause_upd) begin
        csr_d[CAUSE_LSB +: NCAUSE] = new_cause;
        csr_d[FLAG_LSB +: NIEEE]   = csr_q[FLAG_LSB +: NIEEE] | new_cause[NIEEE-1:0];
      end
      for (int i = 0; i < NCOND; i++) csr_d[cond_pos(i)] = cond_d[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) csr_q <= '0;
    else         csr_q <= csr_d;
  end

  fp_csr_trap u_trap (
    .cause_i (csr_q[CAUSE_LSB +: NCAUSE]),
    .en_i    (csr_q[EN_LSB +: NIEEE]),
    .req_o   (exc_req_o)
  );

  assign rd_data_o = csr_q;
  assign rmode_o   = csr_q[RM_W-1:0];
  assign flush_o   = csr_q[FS_BIT];
endmodule

// File: rtl/fp_csr_chk.sv
module fp_csr_chk
  import fp_csr_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [XLEN-1:0]   wr_data_i,
  input logic [XLEN-1:0]   rd_data_o,
  input logic              done_valid_i,
  input logic [1:0]        done_class_i,
  input logic              exc_req_o
);
  a_r2_rsv_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[RSV_LSB +: RSV_W] == '0);

  a_r3_write_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o == ($past(wr_data_i) & ~RSV_MASK));

  a_r4_cause_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !(done_valid_i && (done_class_i == CLS_ARITH || done_class_i == CLS_DIV)))
      |=> $stable(rd_data_o[CAUSE_LSB +: NCAUSE]));

  a_r5_flags_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ((rd_data_o[FLAG_LSB +: NIEEE] & $past(rd_data_o[FLAG_LSB +: NIEEE]))
                  == $past(rd_data_o[FLAG_LSB +: NIEEE])));

  a_r9_e_traps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[CAUSE_LSB + CB_E] |-> exc_req_o);
endmodule

bind fp_csr fp_csr_chk chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .wr_data_i    (wr_data_i),
  .rd_data_o    (rd_data_o),
  .done_valid_i (done_valid_i),
  .done_class_i (done_class_i),
  .exc_req_o    (exc_req_o)
);

// File: tb/fp_csr_tb_top.sv
module fp_csr_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        dv = 1'b0;
  logic [1:0]  dcls = '0;
  logic [5:0]  dexc = '0;
  logic        dden = 1'b0;
  logic        dcmp = 1'b0;
  logic [2:0]  dcidx = '0;
  logic [1:0]  rmode;
  logic        flush;
  logic        exc_req;

  int unsigned n_run = 0, n_fail = 0;
  bit          done = 1'b0;
  logic [31:0] m = '0;

  always #10 clk = ~clk;

  fp_csr dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .done_valid_i(dv), .done_class_i(dcls),
    .done_exc_i(dexc), .done_denorm_i(dden), .done_cmp_i(dcmp),
    .done_cidx_i(dcidx), .rmode_o(rmode), .flush_o(flush), .exc_req_o(exc_req)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // behavioural model of one clock edge
  task automatic model_step();
    logic [5:0] c;
    int pos;
    if (wr_en) begin
      m = wr_data & 32'hFF83_FFFF;
    end else if (dv) begin
      if (dcls == 2'd1 || dcls == 2'd2) begin
        c[5] = dexc[5] | (dden & ~m[24]);
        c[4] = dexc[4];
        c[3] = dexc[3] & (dcls == 2'd2);
        c[2:0] = dexc[2:0];
        m[17:12] = c;
        m[6:2] = m[6:2] | c[4:0];
      end else if (dcls == 2'd3) begin
        pos = (dcidx == 0) ? 23 : 24 + int'(dcidx);
        m[pos] = dcmp;
      end
    end
  endtask

  task automatic compare_all();
    logic exp_req;
    exp_req = m[17] | (|(m[16:12] & m[11:7]));
    chk("R2 reserved", 32'(rd_data[22:18]), 32'(m[22:18]));
    chk("R4 cause", 32'(rd_data[17:12]), 32'(m[17:12]));
    chk("R5 flags", 32'(rd_data[6:2]), 32'(m[6:2]));
    chk("R8 cond", {rd_data[31:23], 23'd0}, {m[31:23], 23'd0});
    chk("R3 word", rd_data, m);
    chk("R9 exc_req", 32'(exc_req), 32'(exp_req));
    chk("R10 rmode", 32'(rmode), 32'(m[1:0]));
    chk("R10 flush", 32'(flush), 32'(m[24]));
  endtask

  task automatic cycle();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    wr_en = 0; dv = 0; dden = 0; dexc = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset word", rd_data, 32'h0);
    chk("R1 reset req", 32'(exc_req), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {rd_data[31:2], rmode}, 32'h0);
    chk("R1 after release flush", 32'(flush), 32'h0);

    // R2: all-ones write leaves reserved bits at zero
    wr_en = 1; wr_data = 32'hFFFF_FFFF; cycle();
    chk("R2 all-ones write", rd_data, 32'hFF83_FFFF);
    // R3: write beats a same-cycle completion
    wr_en = 1; wr_data = 32'h0000_0003; dv = 1; dcls = 2'd1; dexc = 6'h3F; cycle();
    chk("R3 write priority", rd_data, 32'h0000_0003);
    idle();
    // R6: divide-by-zero raw under plain arithmetic class clears Z
    dv = 1; dcls = 2'd1; dexc = 6'b001000; cycle();
    chk("R6 Z arith", 32'(rd_data[15]), 32'h0);
    dcls = 2'd2; cycle();
    chk("R6 Z div", 32'(rd_data[15]), 32'h1);
    // R7: denormal with FS=0 then FS=1
    idle(); dv = 1; dcls = 2'd1; dden = 1; cycle();
    chk("R7 denorm FS0", 32'(rd_data[17]), 32'h1);
    idle(); wr_en = 1; wr_data = 32'h0100_0000; cycle();
    idle(); dv = 1; dcls = 2'd1; dden = 1; cycle();
    chk("R7 denorm FS1", 32'(rd_data[17]), 32'h0);
    // R9: enable set over existing cause
    idle(); dv = 1; dcls = 2'd1; dexc = 6'b000100; cycle();
    chk("R9 no enable", 32'(exc_req), 32'h0);
    idle(); wr_en = 1; wr_data = rd_data | 32'h0000_0200; cycle();
    chk("R9 enable over cause", 32'(exc_req), 32'h1);
    idle(); dv = 1; dcls = 2'd3; dcidx = 3'd7; dcmp = 1; cycle();
    chk("R8 cond7 bit31", 32'(rd_data[31]), 32'h1);
    chk("R4 compare keeps cause", 32'(rd_data[14]), 32'h1);
    idle();

    for (int i = 0; i < 4000; i++) begin
      wr_en   = ($urandom_range(0, 15) == 0);
      wr_data = $urandom;
      dv      = ($urandom_range(0, 3) != 0);
      dcls    = 2'($urandom_range(0, 3));
      dexc    = ($urandom_range(0, 1) == 0) ? 6'($urandom) : 6'd0;
      dden    = ($urandom_range(0, 7) == 0);
      dcmp    = 1'($urandom);
      dcidx   = 3'($urandom);
      cycle();
    end
    idle(); cycle();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule